// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Sectioned Result Preload

This block multiplies two 12-bit operands and folds each product into a 27-bit result register. Both operands are read either as two's complement or as unsigned magnitude. An optional rounding term can be added so that the upper 12 bits of the product give a correctly rounded short result. A result write does one of three things: it loads the product, adds the product to the register, or subtracts the register from the product.

Each operand has its own register with its own load strobe. A third strobe writes the result register. All state runs on one system clock, and the strobes are clock enables. The result register is split into three sections: extended (26:24), high (23:12) and low (11:0). Each section has an active-low output enable. A preload control lets any subset of sections take a value from the shared result bus in place of the accumulated value. The three-state pins are modelled as a per-section drive enable, a value output and a separate bus input.

Top module: `mac_preload`

## Requirements
- R1: `opA` is captured only when `loadA` is high, and `opB` only when `loadB` is high. An operand whose strobe is low keeps its previous value.
- R2: The four mode controls `ctlRound`, `ctlSigned`, `ctlAccum` and `ctlSub` are captured in any cycle where `loadA` or `loadB` is high. Changes to them at other times have no effect on later results.
- R3: With the captured signed control at 1, both operands are two's complement and the 24-bit product is sign-extended to 27 bits. With it at 0, both operands are unsigned and the product is zero-extended.
- R4: With the captured round control at 1, the value 2048 (bit 11) is added to the extended product.
- R5: On a result write with preload low, the captured controls select the value stored. Accum=0 and sub=0 store the product. Accum=1 and sub=0 store product plus register. Accum=1 and sub=1 store product minus register. Accum=0 with sub=1 is not a legal combination: it stores the product and is flagged by an assertion.
- R6: All arithmetic wraps modulo 2^27 with no indication.
- R7: On a result write with `preload` high, each section whose enable input is high (`oeExtN`, `oeHighN`, `oeLowN`) loads its bits from `resIn`.
- R8: `resDriveEn` bit 2/1/0 (extended/high/low) is 1 exactly when `preload` is low and that section's enable is low. `resOut` always shows the register.
- R9: During a preload write, sections whose enable is low keep their value. In any cycle without `resStrobe`, the whole register holds.
- R10: Reset (`rstN` low) clears both operand registers, the captured controls and the result register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opA | input | 12 | Operand A |
| opB | input | 12 | Operand B |
| loadA | input | 1 | Capture strobe for operand A and mode controls |
| loadB | input | 1 | Capture strobe for operand B and mode controls |
| ctlRound | input | 1 | Rounding request |
| ctlSigned | input | 1 | 1 = two's complement, 0 = unsigned |
| ctlAccum | input | 1 | Accumulate select |
| ctlSub | input | 1 | Subtract select |
| resStrobe | input | 1 | Result register write strobe |
| preload | input | 1 | Result write takes bus data for disabled sections |
| oeExtN | input | 1 | Active-low enable, extended section |
| oeHighN | input | 1 | Active-low enable, high section |
| oeLowN | input | 1 | Active-low enable, low section |
| resIn | input | 27 | Bus value seen at the result pins |
| resOut | output | 27 | Result register value |
| resDriveEn | output | 3 | Per-section pin drive enable {ext, high, low} |

## Verification
The bench targets several corner cases, and each wrong design fails in a visible way:
- Signed extremes (-2048 times 2047, -1 times -1) and unsigned full scale (4095 times 4095): a design that extends the product with the wrong sign bit, or multiplies without extension, gives wrong upper bits.
- Subtract mode: a design that takes register minus product gives the negated result.
- Rounding: a design that adds the rounding term at the wrong bit shifts the result.
- Single-strobe updates, one operand at a time: a design that latches both operands, or the controls, on the wrong strobe uses a stale operand or stale signedness.
- Partial preloads: a design that writes the accumulated value in the same cycle, or loads sections whose enable is low, corrupts the kept sections.
- A preload to all ones followed by adding one: a design that saturates, or carries beyond 27 bits, fails this wrap check.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    MODE_LOAD = 2'd0,
    MODE_ADD  = 2'd1,
    MODE_SUB  = 2'd2
  } accMode_t;

  // strobes passed from control to datapath
  typedef struct packed {
    logic     capA;
    logic     capB;
    logic     wrAcc;
    logic [2:0] wrSec;   // {ext, high, low}
    accMode_t mode;
    logic     roundEn;
    logic     signedEn;
  } macStrobes_t;
endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        loadA,
  input  logic        loadB,
  input  logic        ctlRound,
  input  logic        ctlSigned,
  input  logic        ctlAccum,
  input  logic        ctlSub,
  input  logic        resStrobe,
  input  logic        preload,
  input  logic [2:0]  oeN,
  output macStrobes_t strobes,
  output logic [2:0]  driveEn,
  output logic        undefMode
);
  logic rndQ, tcQ, accQ, subQ;
  logic ctlCapture;

  assign ctlCapture = loadA | loadB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rndQ <= 1'b0;
      tcQ  <= 1'b0;
      accQ <= 1'b0;
      subQ <= 1'b0;
    end else if (ctlCapture) begin
      rndQ <= ctlRound;
      tcQ  <= ctlSigned;
      accQ <= ctlAccum;
      subQ <= ctlSub;
    end
  end

  always_comb begin
    strobes          = '0;
    strobes.capA     = loadA;
    strobes.capB     = loadB;
    strobes.roundEn  = rndQ;
    strobes.signedEn = tcQ;
    strobes.wrAcc    = resStrobe & ~preload;
    strobes.wrSec    = {3{resStrobe & preload}} & oeN;
    if (accQ && subQ)      strobes.mode = MODE_SUB;
    else if (accQ)         strobes.mode = MODE_ADD;
    else                   strobes.mode = MODE_LOAD;
  end

  assign driveEn   = ~oeN & {3{~preload}};
  assign undefMode = resStrobe & ~preload & ~accQ & subQ;
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
#(
  parameter int WIDTH = 12,
  parameter int GUARD = 3,
  localparam int PROD_W = 2 * WIDTH,
  localparam int ACC_W  = PROD_W + GUARD
) (
  input  logic              clk,
  input  logic              rstN,
  input  macStrobes_t       strobes,
  input  logic [WIDTH-1:0]  opA,
  input  logic [WIDTH-1:0]  opB,
  input  logic [ACC_W-1:0]  resIn,
  output logic [ACC_W-1:0]  accOut
);
  localparam logic [ACC_W-1:0] RND_ONE = ACC_W'(1) << (WIDTH - 1);

  logic [WIDTH-1:0]  aReg, bReg;
  logic [PROD_W-1:0] extA, extB, prodFull;
  logic [ACC_W-1:0]  prodExt, accNext, accD, accReg;
  logic              accWe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg <= '0;
      bReg <= '0;
    end else begin
      if (strobes.capA) aReg <= opA;
      if (strobes.capB) bReg <= opB;
    end
  end

  // extend operands to product width, then keep the low product bits
  assign extA     = {{WIDTH{strobes.signedEn & aReg[WIDTH-1]}}, aReg};
  assign extB     = {{WIDTH{strobes.signedEn & bReg[WIDTH-1]}}, bReg};
  assign prodFull = extA * extB;
  assign prodExt  = {{GUARD{strobes.signedEn & prodFull[PROD_W-1]}}, prodFull}
                  + (strobes.roundEn ? RND_ONE : '0);

  always_comb begin
    unique case (strobes.mode)
      MODE_ADD: accNext = prodExt + accReg;
      MODE_SUB: accNext = prodExt - accReg;
      default:  accNext = prodExt;
    endcase
  end

  // per-section next value: bus data, accumulated value or hold
  for (genvar s = 0; s < 3; s++) begin : g_sec
    localparam int LSB = s * WIDTH;
    localparam int MSB = (s == 2) ? ACC_W - 1 : LSB + WIDTH - 1;
    assign accD[MSB:LSB] = strobes.wrSec[s] ? resIn[MSB:LSB]
                         : strobes.wrAcc    ? accNext[MSB:LSB]
                         :                    accReg[MSB:LSB];
  end

  assign accWe = strobes.wrAcc | (|strobes.wrSec);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      accReg <= '0;
    else if (accWe) accReg <= accD;
  end

  assign accOut = accReg;
endmodule

// File: rtl/mac_preload.sv
module mac_preload
  import mac_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [11:0] opA,
  input  logic [11:0] opB,
  input  logic        loadA,
  input  logic        loadB,
  input  logic        ctlRound,
  input  logic        ctlSigned,
  input  logic        ctlAccum,
  input  logic        ctlSub,
  input  logic        resStrobe,
  input  logic        preload,
  input  logic        oeExtN,
  input  logic        oeHighN,
  input  logic        oeLowN,
  input  logic [26:0] resIn,
  output logic [26:0] resOut,
  output logic [2:0]  resDriveEn
);
  macStrobes_t strobes;
  logic        undefMode;

  mac_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .loadA     (loadA),
    .loadB     (loadB),
    .ctlRound  (ctlRound),
    .ctlSigned (ctlSigned),
    .ctlAccum  (ctlAccum),
    .ctlSub    (ctlSub),
    .resStrobe (resStrobe),
    .preload   (preload),
    .oeN       ({oeExtN, oeHighN, oeLowN}),
    .strobes   (strobes),
    .driveEn   (resDriveEn),
    .undefMode (undefMode)
  );

  mac_datapath #(.WIDTH(12), .GUARD(3)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .opA     (opA),
    .opB     (opB),
    .resIn   (resIn),
    .accOut  (resOut)
  );
endmodule

// File: rtl/mac_preload_check.sv
module mac_preload_check (
  input logic        clk,
  input logic        rstN,
  input logic        resStrobe,
  input logic        preload,
  input logic        oeExtN,
  input logic        oeHighN,
  input logic        oeLowN,
  input logic [26:0] resIn,
  input logic [26:0] resOut,
  input logic [2:0]  resDriveEn,
  input logic        undefMode
);
  p_undef_mode_r5: assert property (@(posedge clk) disable iff (!rstN)
    !undefMode);

  p_preload_ext_r7: assert property (@(posedge clk) disable iff (!rstN)
    (resStrobe && preload && oeExtN) |=> resOut[26:24] == $past(resIn[26:24]));

  p_preload_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    (resStrobe && preload && oeLowN) |=> resOut[11:0] == $past(resIn[11:0]));

  p_drive_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    preload |-> resDriveEn == 3'b000);

  p_keep_high_r9: assert property (@(posedge clk) disable iff (!rstN)
    (resStrobe && preload && !oeHighN) |=> $stable(resOut[23:12]));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !resStrobe |=> $stable(resOut));
endmodule

bind mac_preload mac_preload_check u_check (
  .clk        (clk),
  .rstN       (rstN),
  .resStrobe  (resStrobe),
  .preload    (preload),
  .oeExtN     (oeExtN),
  .oeHighN    (oeHighN),
  .oeLowN     (oeLowN),
  .resIn      (resIn),
  .resOut     (resOut),
  .resDriveEn (resDriveEn),
  .undefMode  (undefMode)
);

// File: tb/test_mac_preload.sv
module test_mac_preload;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] opA = '0, opB = '0;
  logic        loadA = 0, loadB = 0;
  logic        ctlRound = 0, ctlSigned = 0, ctlAccum = 0, ctlSub = 0;
  logic        resStrobe = 0, preload = 0;
  logic        oeExtN = 0, oeHighN = 0, oeLowN = 0;
  logic [26:0] resIn = '0;
  logic [26:0] resOut;
  logic [2:0]  resDriveEn;

  int checks = 0;
  int errors = 0;
  longint refAcc = 0;
  localparam longint MASK = 64'h7FF_FFFF;

  always #10 clk = ~clk;

  mac_preload i_mac_preload (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .loadA(loadA), .loadB(loadB),
    .ctlRound(ctlRound), .ctlSigned(ctlSigned), .ctlAccum(ctlAccum), .ctlSub(ctlSub),
    .resStrobe(resStrobe), .preload(preload), .oeExtN(oeExtN), .oeHighN(oeHighN),
    .oeLowN(oeLowN), .resIn(resIn), .resOut(resOut), .resDriveEn(resDriveEn)
  );

  // {a[11:0], b[11:0], round, signed, accum, sub}
  localparam logic [27:0] VEC [10] = '{
    {12'h003, 12'h005, 4'b0000},
    {12'hFFF, 12'hFFF, 4'b0010},
    {12'hFFF, 12'hFFF, 4'b0100},
    {12'h800, 12'h7FF, 4'b0110},
    {12'h002, 12'h003, 4'b0111},
    {12'h100, 12'h009, 4'b1000},
    {12'h7FF, 12'h7FF, 4'b1110},
    {12'h800, 12'h800, 4'b0011},
    {12'h123, 12'h456, 4'b1100},
    {12'hFFF, 12'h001, 4'b0010}
  };

  function automatic longint prodModel(logic [11:0] a, logic [11:0] b,
                                       logic tc, logic rnd);
    longint sa = longint'(a);
    longint sb = longint'(b);
    if (tc && a[11]) sa = sa - 4096;
    if (tc && b[11]) sb = sb - 4096;
    return sa * sb + (rnd ? 64'd2048 : 64'd0);
  endfunction

  task automatic check(string tag, longint got, longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic setCtl(logic rnd, logic tc, logic acc, logic sub);
    ctlRound = rnd; ctlSigned = tc; ctlAccum = acc; ctlSub = sub;
  endtask

  task automatic pulseRes();
    @(negedge clk) resStrobe = 1;
    @(negedge clk) resStrobe = 0;
  endtask

  task automatic doOp(logic [11:0] a, logic [11:0] b,
                      logic rnd, logic tc, logic acc, logic sub);
    longint p;
    @(negedge clk);
    opA = a; opB = b; setCtl(rnd, tc, acc, sub); loadA = 1; loadB = 1;
    @(negedge clk);
    loadA = 0; loadB = 0; resStrobe = 1;
    @(negedge clk);
    resStrobe = 0;
    p = prodModel(a, b, tc, rnd);
    if (acc && sub)  refAcc = (p - refAcc) & MASK;
    else if (acc)    refAcc = (p + refAcc) & MASK;
    else             refAcc = p & MASK;
  endtask

  task automatic doPreload(logic [2:0] oeNSet, logic [26:0] value);
    @(negedge clk);
    {oeExtN, oeHighN, oeLowN} = oeNSet;
    preload = 1; resIn = value; resStrobe = 1;
    setCtl(0, 0, 1, 0);
    #1 check("R8 drivers off during preload", longint'(resDriveEn), 0);
    @(negedge clk);
    resStrobe = 0; preload = 0; {oeExtN, oeHighN, oeLowN} = 3'b000;
    for (int s = 0; s < 3; s++) begin
      if (oeNSet[s]) begin
        longint m = (s == 2) ? 64'h7 << 24 : 64'hFFF << (12 * s);
        refAcc = (refAcc & ~m) | (longint'(value) & m);
      end
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 result cleared in reset", longint'(resOut), 0);
    check("R8 drive with enables low", longint'(resDriveEn), 3'b111);
    rstN = 1;
    @(negedge clk);
    check("R10 result zero after reset", longint'(resOut), 0);

    for (int i = 0; i < 10; i++) begin
      doOp(VEC[i][27:16], VEC[i][15:4], VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0]);
      if (VEC[i][3])      check("R4 rounded result", longint'(resOut), refAcc);
      else if (VEC[i][1]) check("R5 accumulate mode", longint'(resOut), refAcc);
      else                check("R3 product load", longint'(resOut), refAcc);
    end

    // R1 A only: B keeps 001
    @(negedge clk);
    opA = 12'hFFF; opB = 12'h0AA; setCtl(0, 0, 0, 0); loadA = 1;
    @(negedge clk) loadA = 0;
    pulseRes();
    check("R1 A captured alone, B kept", longint'(resOut), 64'd4095);

    // R2 controls captured by B strobe alone; A kept
    @(negedge clk);
    opA = 12'h001; opB = 12'h002; setCtl(0, 1, 0, 0); loadB = 1;
    @(negedge clk) loadB = 0;
    pulseRes();
    check("R2 signed captured on B strobe", longint'(resOut), 64'h7FF_FFFE);

    // R2 control change without strobe ignored
    @(negedge clk) setCtl(1, 0, 1, 0);
    pulseRes();
    check("R2 control change without strobe ignored", longint'(resOut), 64'h7FF_FFFE);
    refAcc = 64'h7FF_FFFE;

    // R9 hold without strobe
    @(negedge clk) begin opA = 12'h555; resIn = 27'h1234567; end
    repeat (3) @(negedge clk);
    check("R9 hold without strobe", longint'(resOut), refAcc);

    // R7 / R9 partial preloads
    doPreload(3'b100, 27'h5ABC123);
    check("R7 extended section preloaded", longint'(resOut), refAcc);
    check("R9 other sections kept", longint'(resOut), 64'h5FF_FFFE);
    doPreload(3'b011, 27'h2ABC123);
    check("R7 high and low preloaded", longint'(resOut), 64'h5AB_C123);

    // R8 partial enables
    @(negedge clk) {oeExtN, oeHighN, oeLowN} = 3'b010;
    #1 check("R8 drive follows enables", longint'(resDriveEn), 3'b101);
    @(negedge clk) {oeExtN, oeHighN, oeLowN} = 3'b000;

    // R6 wrap
    doPreload(3'b111, 27'h7FF_FFFF);
    doOp(12'h001, 12'h001, 0, 0, 1, 0);
    check("R6 wrap to zero", longint'(resOut), 0);

    // R5 subtract with preloaded register
    doPreload(3'b111, 27'd100);
    doOp(12'h003, 12'h003, 0, 0, 1, 1);
    check("R5 product minus register", longint'(resOut), (64'd9 - 64'd100) & MASK);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule